// File: doc/BRIEF.md
# Programmable Fill-Threshold Flag Generator

This block produces the two level warnings of a dual-clock queue. `ae_n` lives in the read-clock domain and goes LOW when the queue is close to empty. `af_n` lives in the write-clock domain and goes LOW when the queue is close to full. The queue keeps its write and read positions as Gray-coded pointers, one bit wider than the address. Each of those pointers is a register in its own domain, and both are handed to this block. Inside, each domain passes the foreign pointer through a two-stage synchronizer. It then converts both pointers back to binary, takes their difference as the fill count, and compares that count against a programmable threshold.

The fill count covers only words still held in memory. A word that has moved into the queue's output register has already advanced the read pointer, so it is not counted. The empty-side threshold `X` is held in the read domain and the full-side threshold `Y` in the write domain. Each is preset during its domain's reset and can be overwritten later with a one-cycle load strobe.

A change made by the foreign domain reaches a flag only after that change has crossed the synchronizer. A change of the local pointer or of the local threshold acts at once, because each flag is combinational from registered state.

Top module: `fill_threshold_flags`

## Requirements
- R1: `ae_n` is LOW when the fill (write count minus read count) is X or less, and HIGH when it is X+1 or more. The fill counts only words in memory, so a word already moved to the output register has advanced the read pointer and is not counted.
- R2: `af_n` is LOW when the fill is DEPTH-Y or more, including a completely full memory of DEPTH words, and HIGH when the fill is DEPTH-Y-1 or less.
- R3: After a write-pointer change that raises the fill to X+1, `ae_n` is still LOW after the first rising `rd_clk` edge and is HIGH after the second.
- R4: After a read-pointer change that lowers the fill to DEPTH-Y-1, `af_n` is still LOW after the first rising `wr_clk` edge and is HIGH after the second.
- R5: A read-pointer change that lowers the fill to X drives `ae_n` LOW before any further `rd_clk` edge. A read never raises `ae_n`.
- R6: A write-pointer change that raises the fill to DEPTH-Y drives `af_n` LOW before any further `wr_clk` edge. A write never raises `af_n`.
- R7: While `rd_rst_n` is LOW, X is loaded with AE_PRESET. While `wr_rst_n` is LOW, Y is loaded with AF_PRESET. A later reset restores these presets and discards any programmed value.
- R8: `cfg_x_we` HIGH at a rising `rd_clk` edge loads `cfg_x` into X, and `cfg_y_we` HIGH at a rising `wr_clk` edge loads `cfg_y` into Y. The flag uses the new threshold right after that edge.
- R9: Pointers are Gray codes of a binary count modulo 2*DEPTH, so the fill is taken modulo 2*DEPTH and stays correct when the pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active LOW |
| wr_ptr_gray | input | PW | Registered Gray write pointer (PW = log2(DEPTH)+1) |
| cfg_y_we | input | 1 | Load strobe for the full-side threshold Y |
| cfg_y | input | PW | New value of Y |
| af_n | output | 1 | Almost-full flag, active LOW, write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active LOW |
| rd_ptr_gray | input | PW | Registered Gray read pointer |
| cfg_x_we | input | 1 | Load strobe for the empty-side threshold X |
| cfg_x | input | PW | New value of X |
| ae_n | output | 1 | Almost-empty flag, active LOW, read domain |

## Verification
Three latencies matter, and the bench samples each at a clock's falling edge, well away from any active edge.

- **Foreign pointer change (R3, R4):** the bench drives the pointer at a falling edge. It expects no change after the next rising edge of the flag's domain, and the new value after the second rising edge.
- **Local pointer change (R5, R6):** the result is sampled a couple of nanoseconds after the change, with no edge in between.
- **Threshold load (R8):** the result is due after the single rising edge that captures the strobe.

For steady-state level checks, including the random phase, the bench first lets four edges of each clock pass, so both synchronizers hold the current pointers.

// File: rtl/fill_flag_pkg.sv
package fill_flag_pkg;

    typedef enum logic {
        FLAG_EMPTY_SIDE = 1'b0,
        FLAG_FULL_SIDE  = 1'b1
    } flag_side_e;

    // Gray to binary; zero upper bits keep the result valid for any narrower width.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
    parameter int PW     = 5,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][PW-1:0] stg;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stg[STAGES-1];
endmodule

// File: rtl/fill_level_flag.sv
module fill_level_flag
    import fill_flag_pkg::*;
#(
    parameter flag_side_e SIDE   = FLAG_EMPTY_SIDE,
    parameter int         DEPTH  = 16,
    parameter int         PW     = 5,
    parameter int         PRESET = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] local_gray,
    input  logic [PW-1:0] remote_gray,
    input  logic          cfg_we,
    input  logic [PW-1:0] cfg_val,
    output logic [PW-1:0] offset,
    output logic          flag_n
);
    localparam logic [PW:0] DEPTH_W = (PW+1)'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] thr;
    } flag_state_t;

    flag_state_t   st_d, st_q;
    logic [PW-1:0] local_bin;
    logic [PW-1:0] remote_bin;
    logic [PW-1:0] fill;

    assign local_bin  = PW'(gray_to_bin(32'(local_gray)));
    assign remote_bin = PW'(gray_to_bin(32'(remote_gray)));

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.thr = cfg_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr <= PW'(PRESET);
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (SIDE == FLAG_EMPTY_SIDE) begin : g_empty
            // local is the read pointer, remote is the write pointer
            assign fill   = remote_bin - local_bin;
            assign flag_n = (fill > st_q.thr);
        end else begin : g_full
            // local is the write pointer, remote is the read pointer
            assign fill   = local_bin - remote_bin;
            assign flag_n = (({1'b0, fill} + {1'b0, st_q.thr}) < DEPTH_W);
        end
    endgenerate

    assign offset = st_q.thr;
endmodule

// File: rtl/fill_threshold_flags.sv
module fill_threshold_flags
    import fill_flag_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int AE_PRESET   = 4,
    parameter int AF_PRESET   = 4,
    localparam int PW         = $clog2(DEPTH) + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic [PW-1:0] wr_ptr_gray,
    input  logic          cfg_y_we,
    input  logic [PW-1:0] cfg_y,
    output logic          af_n,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic [PW-1:0] rd_ptr_gray,
    input  logic          cfg_x_we,
    input  logic [PW-1:0] cfg_x,
    output logic          ae_n
);
    logic [PW-1:0] wr_gray_in_rd;
    logic [PW-1:0] rd_gray_in_wr;
    logic [PW-1:0] x_cur;
    logic [PW-1:0] y_cur;

    ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .din   (wr_ptr_gray),
        .dout  (wr_gray_in_rd)
    );

    ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .din   (rd_ptr_gray),
        .dout  (rd_gray_in_wr)
    );

    fill_level_flag #(
        .SIDE(FLAG_EMPTY_SIDE), .DEPTH(DEPTH), .PW(PW), .PRESET(AE_PRESET)
    ) u_empty (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .local_gray  (rd_ptr_gray),
        .remote_gray (wr_gray_in_rd),
        .cfg_we      (cfg_x_we),
        .cfg_val     (cfg_x),
        .offset      (x_cur),
        .flag_n      (ae_n)
    );

    fill_level_flag #(
        .SIDE(FLAG_FULL_SIDE), .DEPTH(DEPTH), .PW(PW), .PRESET(AF_PRESET)
    ) u_full (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .local_gray  (wr_ptr_gray),
        .remote_gray (rd_gray_in_wr),
        .cfg_we      (cfg_y_we),
        .cfg_val     (cfg_y),
        .offset      (y_cur),
        .flag_n      (af_n)
    );
endmodule

// File: rtl/fill_threshold_flags_chk.sv
module fill_threshold_flags_chk #(
    parameter int PW = 5
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic [PW-1:0] wr_ptr_gray,
    input logic [PW-1:0] rd_ptr_gray,
    input logic [PW-1:0] x_cur,
    input logic [PW-1:0] y_cur,
    input logic          ae_n,
    input logic          af_n
);
    // Count rd_clk samples over which the foreign write pointer has not moved.
    logic [PW-1:0] wr_seen_q;
    logic [1:0]    wr_quiet_q;
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            wr_seen_q  <= '0;
            wr_quiet_q <= '0;
        end else begin
            wr_seen_q <= wr_ptr_gray;
            if (wr_ptr_gray != wr_seen_q) begin
                wr_quiet_q <= '0;
            end else if (wr_quiet_q != 2'd3) begin
                wr_quiet_q <= wr_quiet_q + 2'd1;
            end
        end
    end

    // Count wr_clk samples over which the foreign read pointer has not moved.
    logic [PW-1:0] rd_seen_q;
    logic [1:0]    rd_quiet_q;
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            rd_seen_q  <= '0;
            rd_quiet_q <= '0;
        end else begin
            rd_seen_q <= rd_ptr_gray;
            if (rd_ptr_gray != rd_seen_q) begin
                rd_quiet_q <= '0;
            end else if (rd_quiet_q != 2'd3) begin
                rd_quiet_q <= rd_quiet_q + 2'd1;
            end
        end
    end

    // R3: with no write in flight and local inputs steady, ae_n holds its value.
    a_r3_ae_settles: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (wr_quiet_q == 2'd3 && $stable(rd_ptr_gray) && $stable(x_cur)) |-> $stable(ae_n));

    // R5: reads alone can only lower the fill, so ae_n cannot rise.
    a_r5_read_never_raises_ae: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (wr_quiet_q == 2'd3 && $stable(x_cur)) |-> !$rose(ae_n));

    // R4: with no read in flight and local inputs steady, af_n holds its value.
    a_r4_af_settles: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (rd_quiet_q == 2'd3 && $stable(wr_ptr_gray) && $stable(y_cur)) |-> $stable(af_n));

    // R6: writes alone can only raise the fill, so af_n cannot rise.
    a_r6_write_never_raises_af: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (rd_quiet_q == 2'd3 && $stable(y_cur)) |-> !$rose(af_n));
endmodule

bind fill_threshold_flags fill_threshold_flags_chk #(.PW(PW)) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .wr_ptr_gray (wr_ptr_gray),
    .rd_ptr_gray (rd_ptr_gray),
    .x_cur       (x_cur),
    .y_cur       (y_cur),
    .ae_n        (ae_n),
    .af_n        (af_n)
);

// File: tb/fill_threshold_flags_test.sv
module fill_threshold_flags_test;
    localparam int DEPTH = 16;
    localparam int PW    = $clog2(DEPTH) + 1;
    localparam int XP    = 4;
    localparam int YP    = 4;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [PW-1:0] wr_ptr_gray = '0, rd_ptr_gray = '0;
    logic          cfg_y_we = 1'b0, cfg_x_we = 1'b0;
    logic [PW-1:0] cfg_y = '0, cfg_x = '0;
    logic          af_n, ae_n;

    int n_chk = 0;
    int n_err = 0;
    int wcnt = 0, rcnt = 0, x_exp = XP, y_exp = YP;

    fill_threshold_flags #(.DEPTH(DEPTH), .SYNC_STAGES(2), .AE_PRESET(XP), .AF_PRESET(YP)) uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_ptr_gray(wr_ptr_gray),
        .cfg_y_we(cfg_y_we), .cfg_y(cfg_y), .af_n(af_n),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ptr_gray(rd_ptr_gray),
        .cfg_x_we(cfg_x_we), .cfg_x(cfg_x), .ae_n(ae_n)
    );

    always #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    function automatic logic [PW-1:0] to_gray(input int v);
        logic [PW-1:0] b;
        b = PW'(v % (2 * DEPTH));
        return b ^ (b >> 1);
    endfunction

    function automatic int fill_now();
        return wcnt - rcnt;
    endfunction

    function automatic logic exp_ae();
        return fill_now() > x_exp;
    endfunction

    function automatic logic exp_af();
        return (fill_now() + y_exp) < DEPTH;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b (fill=%0d x=%0d y=%0d)",
                     req, act, exp, fill_now(), x_exp, y_exp);
        end
    endtask

    task automatic set_wr(input int v);
        wcnt = v;
        wr_ptr_gray = to_gray(v);
    endtask

    task automatic set_rd(input int v);
        rcnt = v;
        rd_ptr_gray = to_gray(v);
    endtask

    task automatic settle();
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic prog_x(input int v);
        @(negedge rd_clk);
        cfg_x_we = 1'b1;
        cfg_x = PW'(v);
        @(negedge rd_clk);
        cfg_x_we = 1'b0;
        x_exp = v;
    endtask

    task automatic prog_y(input int v);
        @(negedge wr_clk);
        cfg_y_we = 1'b1;
        cfg_y = PW'(v);
        @(negedge wr_clk);
        cfg_y_we = 1'b0;
        y_exp = v;
    endtask

    task automatic do_reset();
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        set_wr(0);
        set_rd(0);
        x_exp = XP;
        y_exp = YP;
        repeat (3) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
        settle();
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // Reset state: empty memory
        chk("R1 reset empty ae_n", ae_n, 1'b0);
        chk("R2 reset empty af_n", af_n, 1'b1);

        // Preset X=4 boundary
        set_wr(4); settle();
        chk("R7 preset X, fill=X", ae_n, 1'b0);
        set_wr(5); settle();
        chk("R1 fill=X+1", ae_n, 1'b1);

        // R3: write raising fill to X+1 takes two rd edges
        set_rd(1); settle();
        chk("R1 fill=X after read", ae_n, 1'b0);
        @(negedge rd_clk); set_wr(6);
        @(negedge rd_clk);
        chk("R3 after first rd edge", ae_n, 1'b0);
        @(negedge rd_clk);
        chk("R3 after second rd edge", ae_n, 1'b1);

        // R5: read lowering fill to X acts at once
        settle();
        @(negedge rd_clk); set_rd(2);
        #2;
        chk("R5 immediate fall", ae_n, 1'b0);

        // Full side with preset Y=4 (threshold 12)
        set_wr(13); settle();
        chk("R2 fill=DEPTH-Y-1", af_n, 1'b1);
        set_wr(14); settle();
        chk("R7 preset Y, fill=DEPTH-Y", af_n, 1'b0);

        // R4: read lowering fill to DEPTH-Y-1 takes two wr edges
        @(negedge wr_clk); set_rd(3);
        @(negedge wr_clk);
        chk("R4 after first wr edge", af_n, 1'b0);
        @(negedge wr_clk);
        chk("R4 after second wr edge", af_n, 1'b1);

        // R6: write raising fill to DEPTH-Y acts at once
        settle();
        @(negedge wr_clk); set_wr(15);
        #2;
        chk("R6 immediate fall", af_n, 1'b0);

        // Completely full
        set_wr(19); settle();
        chk("R2 full memory af_n", af_n, 1'b0);
        chk("R1 full memory ae_n", ae_n, 1'b1);

        // R8: threshold programming
        set_rd(12); settle();
        chk("R1 fill=7 with X=4", ae_n, 1'b1);
        prog_x(7);
        chk("R8 X=7 takes effect", ae_n, 1'b0);
        prog_y(2);
        set_wr(25); settle();
        chk("R8 Y=2 fill=13", af_n, 1'b1);
        set_wr(26); settle();
        chk("R8 Y=2 fill=14", af_n, 1'b0);

        // R9: pointers wrap past 2*DEPTH
        set_rd(26); set_wr(37); settle();
        chk("R9 wrap ae_n fill=11", ae_n, 1'b1);
        chk("R9 wrap af_n fill=11", af_n, 1'b1);
        set_rd(30); settle();
        chk("R9 wrap ae_n fill=7", ae_n, 1'b0);

        // R7: second reset restores presets
        do_reset();
        set_wr(5); settle();
        chk("R7 X back to preset", ae_n, 1'b1);
        set_wr(12); settle();
        chk("R7 Y back to preset", af_n, 1'b0);

        // Random traffic and thresholds
        void'($urandom(32'd2024));
        for (int it = 0; it < 300; it++) begin
            int sel;
            int k;
            sel = int'($urandom % 8);
            if (sel == 0) begin
                prog_x(int'($urandom % DEPTH));
            end else if (sel == 1) begin
                prog_y(int'($urandom % (DEPTH + 1)));
            end else if (sel <= 4) begin
                k = 1 + int'($urandom % 3);
                if (k > DEPTH - fill_now()) k = DEPTH - fill_now();
                set_wr(wcnt + k);
            end else begin
                k = 1 + int'($urandom % 3);
                if (k > fill_now()) k = fill_now();
                set_rd(rcnt + k);
            end
            settle();
            chk("R1 random ae_n", ae_n, exp_ae());
            chk("R2 random af_n", af_n, exp_af());
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule